// File: doc/BRIEF.md
# Two-Thread Shared Queue Entry Allocator

This block keeps the entry accounting for one queue that two hardware threads share. Each thread raises an allocate request for one entry and returns entries through a release strobe. The block answers each request in the same cycle with a grant or a refusal. It keeps a per-thread occupancy count and a count of free entries, and shows all three as outputs. The queue storage itself lives elsewhere. A requester whose request is refused holds it and tries again in a later cycle.

The block enforces one of three sharing policies, selected by an input. Under the split policy, each thread is held to half of the queue while both threads are active. This stops a fast thread from taking the entries that a slow thread needs. Under the capped policy, each thread is limited to a programmable number of entries. Under the open policy, either thread may take any free entry. A two-bit activity input tells the block which threads are running. When only one thread runs, the split policy gives that thread the whole queue.

Top module: `shared_q_alloc`

## Requirements
- R1: After reset, both occupancy outputs are 0, the free count equals DEPTH (16), and the round-robin pointer favours thread 0.
- R2: With policy = 0 (split) and both activity bits set, a thread whose occupancy has reached DEPTH/2 is refused. The other thread can still obtain its own DEPTH/2 entries.
- R3: With policy = 0 and only one activity bit set, the active thread is granted until it holds all DEPTH entries.
- R4: With policy = 1 (capped), a thread whose occupancy has reached the threshold input (values 1 to DEPTH) is refused.
- R5: With policy = 2 (open; value 3 behaves the same), an active requesting thread is granted whenever the free count is non-zero, whatever its own occupancy.
- R6: No grant is given while the free count is 0.
- R7: When both threads qualify for a grant and exactly one entry is free, only one thread is granted. The first such conflict after reset goes to thread 0, and each later conflict goes to the thread that lost the previous one.
- R8: A grant and a release for the same thread in the same cycle leave that thread's occupancy and the free count unchanged.
- R9: occ0 + occ1 + free_cnt equals DEPTH in every cycle.
- R10: A thread whose activity bit is low is never granted.
- R11: A release from a thread that holds no entries is ignored.
- R12: A grant output is high only while the matching request is high. The counts change only on the clock edge after a grant or release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| policy | input | 2 | Sharing policy: 0 split, 1 capped, 2 or 3 open |
| thr_active | input | 2 | Bit t high: thread t is running |
| cap_limit | input | 5 | Per-thread entry cap used by the capped policy (1 to 16) |
| alloc_req | input | 2 | Bit t: thread t asks for one entry |
| free_rel | input | 2 | Bit t: thread t returns one entry |
| alloc_gnt | output | 2 | Bit t: the request from thread t is granted this cycle |
| occ0 | output | 5 | Entries held by thread 0 |
| occ1 | output | 5 | Entries held by thread 1 |
| free_cnt | output | 5 | Entries held by neither thread |

## Verification
The assertions assume that the policy, activity and threshold inputs change only between requests. They also assume a thread releases only entries it was granted, so its release count never runs ahead of its grants except in the ignored case at zero. The directed stimulus drives all inputs on the falling edge, changes policy and activity only while the request lines are low, and releases only from threads whose occupancy the bench knows. Each scenario starts from a fresh reset, so its expected counts follow from the requirements alone.

// File: rtl/sqa_pkg.sv
package sqa_pkg;
  typedef enum logic [1:0] {
    POL_SPLIT  = 2'd0,
    POL_CAPPED = 2'd1,
    POL_OPEN   = 2'd2,
    POL_OPEN_B = 2'd3
  } share_pol_t;
endpackage

// File: rtl/sqa_room.sv
// Decides whether one thread still has headroom under the active policy.
module sqa_room
  import sqa_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  share_pol_t    pol,
  input  logic          both_on,
  input  logic [CW-1:0] limit,
  input  logic [CW-1:0] occ,
  output logic          room
);
  localparam logic [CW-1:0] FULL_Q = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_Q = CW'(DEPTH / 2);

  logic [CW-1:0] cap;

  always_comb begin
    unique case (pol)
      POL_SPLIT:  cap = both_on ? HALF_Q : FULL_Q;
      POL_CAPPED: cap = (limit > FULL_Q) ? FULL_Q : limit;
      default:    cap = FULL_Q;
    endcase
    room = occ < cap;
  end
endmodule

// File: rtl/sqa_arb.sv
// Grants against the free count; round-robin on the last free entry.
module sqa_arb #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    want,
  input  logic [CW-1:0] free_q,
  output logic [1:0]    gnt
);
  logic rr_q, rr_d, rr_en;
  logic any_free, two_free, clash;

  always_comb begin
    any_free = free_q != '0;
    two_free = free_q > CW'(1);
    clash    = (want == 2'b11) && any_free && !two_free;
    rr_en    = clash;
    rr_d     = ~rr_q;
    if (clash)         gnt = rr_q ? 2'b10 : 2'b01;
    else if (any_free) gnt = want;
    else               gnt = 2'b00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rr_q <= 1'b0;
    else if (rr_en) rr_q <= rr_d;
  end

  // R7: a single free entry is never handed to both threads
  a_r7_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
    (want == 2'b11 && free_q == CW'(1)) |-> $countones(gnt) == 1);
  // R6: nothing is granted from an empty pool
  a_r6_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (free_q == '0) |-> (gnt == 2'b00));
endmodule

// File: rtl/sqa_occ.sv
// Occupancy counter of one thread.
module sqa_occ #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gnt,
  input  logic          rel,
  output logic          rel_ok,
  output logic [CW-1:0] occ
);
  logic [CW-1:0] occ_d;
  logic          occ_en;

  always_comb begin
    rel_ok = rel && (occ != '0);
    occ_en = gnt ^ rel_ok;
    occ_d  = gnt ? occ + CW'(1) : occ - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      occ <= '0;
    else if (occ_en) occ <= occ_d;
  end

  // R8: grant plus release in one cycle leaves the count alone
  a_r8_swap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt && rel && occ != '0) |=> occ == $past(occ));
  // R11: a release at zero is dropped
  a_r11_empty_rel: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0 && !gnt) |=> occ == '0);
endmodule

// File: rtl/sqa_pool.sv
// Free-entry counter shared by both threads.
module sqa_pool #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    gnt,
  input  logic [1:0]    rel_ok,
  output logic [CW-1:0] free_q
);
  logic [CW-1:0] free_d;
  logic          free_en;
  logic [1:0]    n_take, n_give;

  always_comb begin
    n_take  = {1'b0, gnt[0]} + {1'b0, gnt[1]};
    n_give  = {1'b0, rel_ok[0]} + {1'b0, rel_ok[1]};
    free_en = n_take != n_give;
    free_d  = free_q + CW'(n_give) - CW'(n_take);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       free_q <= CW'(DEPTH);
    else if (free_en) free_q <= free_d;
  end
endmodule

// File: rtl/shared_q_alloc.sv
module shared_q_alloc
  import sqa_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    policy,
  input  logic [1:0]    thr_active,
  input  logic [CW-1:0] cap_limit,
  input  logic [1:0]    alloc_req,
  input  logic [1:0]    free_rel,
  output logic [1:0]    alloc_gnt,
  output logic [CW-1:0] occ0,
  output logic [CW-1:0] occ1,
  output logic [CW-1:0] free_cnt
);
  share_pol_t          pol;
  logic                both_on;
  logic [1:0]          room, want, rel_ok;
  logic [1:0][CW-1:0]  occ;

  assign pol     = share_pol_t'(policy);
  assign both_on = &thr_active;
  assign want    = alloc_req & thr_active & room;

  for (genvar t = 0; t < 2; t++) begin : g_thr
    sqa_room #(.DEPTH(DEPTH)) u_room (
      .pol(pol), .both_on(both_on), .limit(cap_limit),
      .occ(occ[t]), .room(room[t])
    );
    sqa_occ #(.DEPTH(DEPTH)) u_occ (
      .clk(clk), .rst_n(rst_n), .gnt(alloc_gnt[t]), .rel(free_rel[t]),
      .rel_ok(rel_ok[t]), .occ(occ[t])
    );

    // R2: split policy with both threads running caps at half
    a_r2_half_cap: assert property (@(posedge clk) disable iff (!rst_n)
      (policy == 2'd0 && both_on && alloc_gnt[t]) |-> occ[t] < CW'(DEPTH / 2));
    // R4: capped policy never grants at or above the limit
    a_r4_limit: assert property (@(posedge clk) disable iff (!rst_n)
      (policy == 2'd1 && alloc_gnt[t]) |-> occ[t] < cap_limit);
    // R10: an idle thread gets nothing
    a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !thr_active[t] |-> !alloc_gnt[t]);
  end

  sqa_arb #(.DEPTH(DEPTH)) u_arb (
    .clk(clk), .rst_n(rst_n), .want(want), .free_q(free_cnt), .gnt(alloc_gnt)
  );

  sqa_pool #(.DEPTH(DEPTH)) u_pool (
    .clk(clk), .rst_n(rst_n), .gnt(alloc_gnt), .rel_ok(rel_ok), .free_q(free_cnt)
  );

  assign occ0 = occ[0];
  assign occ1 = occ[1];

  // R9: every entry is accounted for exactly once
  a_r9_conserve: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, occ0} + {1'b0, occ1} + {1'b0, free_cnt}) == (CW + 1)'(DEPTH));
  // R12: grants only answer requests
  a_r12_gnt_req: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_gnt & ~alloc_req) == 2'b00);
  // R5: open policy grants a lone active requester while entries remain
  a_r5_open: assert property (@(posedge clk) disable iff (!rst_n)
    (policy[1] && alloc_req == 2'b01 && thr_active[0] && free_cnt != '0)
      |-> alloc_gnt == 2'b01);
endmodule

// File: tb/shared_q_alloc_test.sv
module shared_q_alloc_test;
  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    policy, thr_active, alloc_req, free_rel, alloc_gnt;
  logic [CW-1:0] cap_limit, occ0, occ1, free_cnt;
  int            checks = 0;
  int            errors = 0;
  logic [1:0]    g;

  always #5 clk = ~clk;

  shared_q_alloc #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .policy(policy), .thr_active(thr_active),
    .cap_limit(cap_limit), .alloc_req(alloc_req), .free_rel(free_rel),
    .alloc_gnt(alloc_gnt), .occ0(occ0), .occ1(occ1), .free_cnt(free_cnt)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic counts(input string tag, input int e0, input int e1, input int ef);
    chk({tag, " occ0"}, int'(occ0), e0);
    chk({tag, " occ1"}, int'(occ1), e1);
    chk({tag, " free"}, int'(free_cnt), ef);
    chk("R9 sum", int'(occ0) + int'(occ1) + int'(free_cnt), DEPTH);
  endtask

  // One cycle: drive at falling edge, sample grant, counts update at rising edge.
  task automatic cyc(input logic [1:0] r, input logic [1:0] l);
    alloc_req = r;
    free_rel  = l;
    #1 g = alloc_gnt;
    @(negedge clk);
    alloc_req = 2'b00;
    free_rel  = 2'b00;
  endtask

  task automatic burst(input logic [1:0] r, input int n, output int got0, output int got1);
    got0 = 0;
    got1 = 0;
    for (int i = 0; i < n; i++) begin
      cyc(r, 2'b00);
      got0 += int'(g[0]);
      got1 += int'(g[1]);
    end
  endtask

  task automatic do_reset(input logic [1:0] pol, input logic [1:0] act, input int lim);
    rst_n = 1'b0;
    policy = pol;
    thr_active = act;
    cap_limit = CW'(lim);
    alloc_req = 2'b00;
    free_rel = 2'b00;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset;
    do_reset(2'd2, 2'b11, 16);
    counts("R1 reset", 0, 0, DEPTH);
    #1 chk("R12 idle gnt", int'(alloc_gnt), 0);
  endtask

  task automatic t_split;
    int a, b;
    do_reset(2'd0, 2'b11, 16);
    burst(2'b01, 10, a, b);
    chk("R2 fast thread grants", a, DEPTH / 2);
    counts("R2 after t0 burst", 8, 0, 8);
    burst(2'b10, 9, a, b);
    chk("R2 slow thread grants", b, DEPTH / 2);
    counts("R2 both halves", 8, 8, 0);
    cyc(2'b00, 2'b01);
    counts("R8 prep release", 7, 8, 1);
    cyc(2'b01, 2'b01);
    chk("R8 swap grant", int'(g), 1);
    counts("R8 swap", 7, 8, 1);
    cyc(2'b10, 2'b00);
    chk("R2 t1 at half refused", int'(g), 0);
  endtask

  task automatic t_single;
    int a, b;
    do_reset(2'd0, 2'b01, 16);
    burst(2'b01, 17, a, b);
    chk("R3 lone thread grants", a, DEPTH);
    counts("R3 whole queue", 16, 0, 0);
    cyc(2'b01, 2'b00);
    chk("R6 empty refusal", int'(g), 0);
    cyc(2'b00, 2'b01);
    cyc(2'b10, 2'b00);
    chk("R10 idle thread refused", int'(g), 0);
    counts("R10 counts", 15, 0, 1);
  endtask

  task automatic t_capped;
    int a, b;
    do_reset(2'd1, 2'b11, 5);
    burst(2'b01, 7, a, b);
    chk("R4 t0 grants", a, 5);
    burst(2'b10, 7, a, b);
    chk("R4 t1 grants", b, 5);
    counts("R4 counts", 5, 5, 6);
  endtask

  task automatic t_open;
    int a, b;
    do_reset(2'd2, 2'b11, 16);
    burst(2'b01, 16, a, b);
    chk("R5 open grants", a, DEPTH);
    cyc(2'b10, 2'b00);
    chk("R6 pool empty", int'(g), 0);
    counts("R5 counts", 16, 0, 0);
  endtask

  task automatic t_clash;
    int a, b;
    do_reset(2'd3, 2'b11, 16);
    burst(2'b01, 15, a, b);
    counts("R7 prep", 15, 0, 1);
    cyc(2'b11, 2'b00);
    chk("R7 first clash to t0", int'(g), 1);
    cyc(2'b00, 2'b01);
    cyc(2'b11, 2'b00);
    chk("R7 second clash to t1", int'(g), 2);
    counts("R7 mid", 15, 1, 0);
    cyc(2'b00, 2'b10);
    cyc(2'b11, 2'b00);
    chk("R7 third clash to t0", int'(g), 1);
    counts("R7 end", 16, 0, 0);
  endtask

  task automatic t_empty_rel;
    do_reset(2'd2, 2'b11, 16);
    cyc(2'b00, 2'b11);
    counts("R11 release at zero", 0, 0, DEPTH);
    cyc(2'b11, 2'b00);
    chk("R5 both granted", int'(g), 3);
    counts("R12 counts after edge", 1, 1, 14);
  endtask

  initial begin
    t_reset();
    t_split();
    t_single();
    t_capped();
    t_open();
    t_clash();
    t_empty_rel();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule